// File: doc/BRIEF.md
# Downward-Growing Stack Pointer

This block holds the 16-bit pointer to the top of a stack that grows toward lower data-memory addresses. For every stack access it produces the memory address and a write or read strobe. Memory, the program counter and instruction decoding are outside the block. Software loads the pointer one byte at a time, high half and low half, and reads the whole value back on `sp`.

There are four access requests. A single-byte push writes at the current pointer and then moves the pointer down by one. A single-byte pop first moves the pointer up by one and then reads there. A return-address push, used for a call or an interrupt entry, stores two bytes over two cycles, low byte first, and moves the pointer down by two. A return-address pop reverses that order and moves the pointer up by two.

The pointer resets to zero, so software must load it before any stack use. The usual value is the last address of internal data memory. A read strobe at an address above that configured limit raises an underflow indication.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset `sp` is 0x0000, `busy` is 0 and neither `mem_wr` nor `mem_rd` is asserted.
- R2: A byte push (`push_byte`) drives `mem_addr` = `sp` with `mem_wr`=1 in its cycle, and `sp` is one lower in the next cycle.
- R3: A byte pop (`pop_byte`) drives `mem_addr` = `sp`+1 with `mem_rd`=1 in its cycle, and `sp` is one higher in the next cycle.
- R4: A return-address push (`call_push`) writes in two consecutive cycles. The first writes at `sp` with `ra_hi`=0 (low byte). The second writes at `sp`−1 with `ra_hi`=1 and `busy`=1. After both, `sp` is two lower.
- R5: A return-address pop (`ret_pop`) reads in two consecutive cycles. The first reads at `sp`+1 with `ra_hi`=1 (high byte). The second reads at `sp`+2 with `ra_hi`=0 and `busy`=1. After both, `sp` is two higher.
- R6: While `busy`=1, all four request inputs are ignored and the second transfer completes unchanged.
- R7: `wr_hi` loads `wr_data` into bits 15:8 of the pointer and `wr_lo` loads it into bits 7:0. The other half keeps its value. Both strobes together load both halves.
- R8: A software write takes precedence. In its cycle there is no memory strobe, any request is dropped, and a pending second return-address transfer is cancelled.
- R9: When several requests arrive together, the priority order is `call_push`, then `ret_pop`, then `push_byte`, then `pop_byte`.
- R10: `underflow` is 1 exactly when `mem_rd`=1 and `mem_addr` is greater than the parameter `STACK_TOP`.
- R11: Pointer arithmetic wraps modulo 2^16. A push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF reads address 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Software write of the pointer's high byte |
| wr_lo | input | 1 | Software write of the pointer's low byte |
| wr_data | input | 8 | Byte written by software |
| push_byte | input | 1 | Single-byte push request |
| pop_byte | input | 1 | Single-byte pop request |
| call_push | input | 1 | Return-address push request |
| ret_pop | input | 1 | Return-address pop request |
| mem_addr | output | 16 | Data-memory address of the current stack access |
| mem_wr | output | 1 | Stack write in this cycle |
| mem_rd | output | 1 | Stack read in this cycle |
| ra_hi | output | 1 | Return-address byte moved this cycle is the high byte |
| busy | output | 1 | Second cycle of a return-address transfer |
| sp | output | 16 | Current pointer value |
| underflow | output | 1 | Read above the configured stack top |

## Verification
On every cycle the assertions check the following:
- each single-byte operation's address and its one-step pointer change;
- the byte order of both halves of a return-address transfer;
- that a software write suppresses every memory strobe;
- that a write and a read strobe never occur together;
- that the underflow flag matches the read address.

Some behaviours only the bench's scenarios can show:
- the net two-step pointer change across a call or a return;
- that requests during the second cycle are ignored;
- the cancellation of a pending transfer by a software write;
- the priority among simultaneous requests;
- wrap-around at the ends of the address space.

The bench sweeps these over pointer values at the byte and address-space boundaries.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int BW = 8,
  parameter logic [2*BW-1:0] STACK_TOP = 16'h085F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [BW-1:0] wr_data,
  input  logic          push_byte,
  input  logic          pop_byte,
  input  logic          call_push,
  input  logic          ret_pop,
  output logic [2*BW-1:0] mem_addr,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic          ra_hi,
  output logic          busy,
  output logic [2*BW-1:0] sp,
  output logic          underflow
);
  localparam int AW = 2 * BW;
  localparam logic [AW-1:0] ONE = AW'(1);

  typedef enum logic [1:0] {PH_IDLE, PH_CALL2, PH_RET2} phase_t;

  phase_t         phase, phase_nxt;
  logic [AW-1:0]  sp_q, sp_nxt;
  logic [AW-1:0]  sp_up;
  logic           sw;

  assign sw    = wr_hi | wr_lo;
  assign sp_up = sp_q + ONE;

  always_comb begin
    phase_nxt = PH_IDLE;
    sp_nxt    = sp_q;
    mem_addr  = sp_q;
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    ra_hi     = 1'b0;
    if (sw) begin
      sp_nxt = {wr_hi ? wr_data : sp_q[AW-1:BW], wr_lo ? wr_data : sp_q[BW-1:0]};
    end else if (phase == PH_CALL2) begin
      mem_wr = 1'b1;
      ra_hi  = 1'b1;
      sp_nxt = sp_q - ONE;
    end else if (phase == PH_RET2) begin
      mem_addr = sp_up;
      mem_rd   = 1'b1;
      sp_nxt   = sp_up;
    end else if (call_push) begin
      mem_wr    = 1'b1;
      sp_nxt    = sp_q - ONE;
      phase_nxt = PH_CALL2;
    end else if (ret_pop) begin
      mem_addr  = sp_up;
      mem_rd    = 1'b1;
      ra_hi     = 1'b1;
      sp_nxt    = sp_up;
      phase_nxt = PH_RET2;
    end else if (push_byte) begin
      mem_wr = 1'b1;
      sp_nxt = sp_q - ONE;
    end else if (pop_byte) begin
      mem_addr = sp_up;
      mem_rd   = 1'b1;
      sp_nxt   = sp_up;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      phase <= PH_IDLE;
    end else begin
      sp_q  <= sp_nxt;
      phase <= phase_nxt;
    end
  end

  assign sp        = sp_q;
  assign busy      = (phase != PH_IDLE);
  assign underflow = mem_rd && (mem_addr > STACK_TOP);
endmodule

// File: rtl/stack_ptr_chk.sv
module stack_ptr_chk #(
  parameter int BW = 8,
  parameter logic [2*BW-1:0] STACK_TOP = 16'h085F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_hi,
  input logic          wr_lo,
  input logic [BW-1:0] wr_data,
  input logic          push_byte,
  input logic          pop_byte,
  input logic          call_push,
  input logic          ret_pop,
  input logic [2*BW-1:0] mem_addr,
  input logic          mem_wr,
  input logic          mem_rd,
  input logic          ra_hi,
  input logic          busy,
  input logic [2*BW-1:0] sp,
  input logic          underflow
);
  logic sw_any;
  logic idle_push;
  logic idle_pop;

  assign sw_any    = wr_hi | wr_lo;
  assign idle_push = !busy && !sw_any && push_byte && !call_push && !ret_pop;
  assign idle_pop  = !busy && !sw_any && pop_byte && !push_byte && !call_push && !ret_pop;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sp == '0 && !busy));

  // R2
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_push |-> (mem_wr && mem_addr == sp));

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_push |=> (sp == $past(sp) - 1'b1));

  // R3
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pop |-> (mem_rd && mem_addr == sp + 1'b1));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pop |=> (sp == $past(sp) + 1'b1));

  // R4
  call_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sw_any && call_push) |=> busy);

  // R4
  call_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_wr) |-> ra_hi);

  // R5
  ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rd) |-> !ra_hi);

  // R8
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_any |-> (!mem_wr && !mem_rd));

  // R8
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd}));

  // R10
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow == (mem_rd && mem_addr > STACK_TOP));
endmodule

bind stack_ptr_unit stack_ptr_chk #(.BW(BW), .STACK_TOP(STACK_TOP)) u_chk (.*);

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  localparam logic [15:0] TOP = 16'h085F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_hi = 0, wr_lo = 0, push_byte = 0, pop_byte = 0, call_push = 0, ret_pop = 0;
  logic [7:0] wr_data = '0;
  logic [15:0] mem_addr, sp;
  logic mem_wr, mem_rd, ra_hi, busy, underflow;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  stack_ptr_unit #(.BW(8), .STACK_TOP(TOP)) i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .push_byte(push_byte), .pop_byte(pop_byte), .call_push(call_push), .ret_pop(ret_pop),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .ra_hi(ra_hi),
    .busy(busy), .sp(sp), .underflow(underflow));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    wr_hi = 1; wr_data = v[15:8];
    #1 chk(!mem_wr && !mem_rd, "R7", {mem_wr, mem_rd}, 0);
    @(negedge clk);
    wr_hi = 0; wr_lo = 1; wr_data = v[7:0];
    @(negedge clk);
    wr_lo = 0;
    #1 chk(sp == v, "R7", sp, v);
  endtask

  task automatic drop_all();
    push_byte = 0; pop_byte = 0; call_push = 0; ret_pop = 0; wr_hi = 0; wr_lo = 0;
  endtask

  initial begin
    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100,
                              16'h085E, 16'h085F, 16'h0860, 16'hFFFF};
    fork
      begin
        repeat (3) @(negedge clk);
        #1 chk(sp == 16'h0 && !busy && !mem_wr && !mem_rd, "R1", sp, 0);
        rst_n = 1;
        step();
        chk(sp == 16'h0 && !busy, "R1", sp, 0);

        foreach (vals[i]) begin
          logic [15:0] v;
          v = vals[i];

          load(v);
          @(negedge clk); push_byte = 1;
          #1 chk(mem_wr && !mem_rd && mem_addr == v, "R2", mem_addr, v);
          @(negedge clk); push_byte = 0;
          #1 chk(sp == v - 16'd1, "R2 R11", sp, v - 16'd1);

          load(v);
          @(negedge clk); pop_byte = 1;
          #1 chk(mem_rd && !mem_wr && mem_addr == v + 16'd1, "R3 R11", mem_addr, v + 16'd1);
          chk(underflow == (v + 16'd1 > TOP), "R10", underflow, (v + 16'd1 > TOP));
          @(negedge clk); pop_byte = 0;
          #1 chk(sp == v + 16'd1, "R3", sp, v + 16'd1);

          load(v);
          @(negedge clk); call_push = 1;
          #1 chk(mem_wr && !ra_hi && mem_addr == v && !busy, "R4", mem_addr, v);
          @(negedge clk); call_push = 0; pop_byte = 1; ret_pop = 1;
          #1 chk(mem_wr && ra_hi && busy && mem_addr == v - 16'd1, "R4 R6", mem_addr, v - 16'd1);
          @(negedge clk); drop_all();
          #1 chk(sp == v - 16'd2 && !busy && !mem_wr && !mem_rd, "R4 R6", sp, v - 16'd2);

          load(v);
          @(negedge clk); ret_pop = 1;
          #1 chk(mem_rd && ra_hi && mem_addr == v + 16'd1, "R5", mem_addr, v + 16'd1);
          chk(underflow == (v + 16'd1 > TOP), "R10", underflow, (v + 16'd1 > TOP));
          @(negedge clk); ret_pop = 0; push_byte = 1; call_push = 1;
          #1 chk(mem_rd && !ra_hi && busy && mem_addr == v + 16'd2, "R5 R6", mem_addr, v + 16'd2);
          @(negedge clk); drop_all();
          #1 chk(sp == v + 16'd2 && !busy, "R5 R6", sp, v + 16'd2);

          load(v);
          @(negedge clk); push_byte = 1; wr_lo = 1; wr_data = 8'h5A;
          #1 chk(!mem_wr && !mem_rd, "R8", {mem_wr, mem_rd}, 0);
          @(negedge clk); drop_all();
          #1 chk(sp == {v[15:8], 8'h5A}, "R8 R7", sp, {v[15:8], 8'h5A});

          load(v);
          @(negedge clk); call_push = 1;
          @(negedge clk); call_push = 0; wr_hi = 1; wr_data = 8'h33;
          #1 chk(!mem_wr && !mem_rd, "R8", {mem_wr, mem_rd}, 0);
          @(negedge clk); drop_all();
          #1 chk(!busy && sp == {8'h33, 8'(v - 16'd1)}, "R8", sp, {8'h33, 8'(v - 16'd1)});

          load(v);
          @(negedge clk); push_byte = 1; pop_byte = 1; call_push = 1; ret_pop = 1;
          #1 chk(mem_wr && !ra_hi && mem_addr == v, "R9", mem_addr, v);
          @(negedge clk); drop_all();
          @(negedge clk); ret_pop = 1; push_byte = 1; pop_byte = 1;
          #1 chk(mem_rd && ra_hi && mem_addr == v - 16'd1, "R9", mem_addr, v - 16'd1);
          @(negedge clk); drop_all();
          @(negedge clk); push_byte = 1; pop_byte = 1;
          #1 chk(mem_wr && mem_addr == v, "R9", mem_addr, v);
          @(negedge clk); drop_all();
          #1 chk(sp == v - 16'd1, "R9", sp, v - 16'd1);
        end

        @(negedge clk); wr_hi = 1; wr_lo = 1; wr_data = 8'hA7;
        @(negedge clk); drop_all();
        #1 chk(sp == 16'hA7A7, "R7", sp, 16'hA7A7);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule